// File: doc/BRIEF.md
# Serial memory slave address front end

This block is the addressing front end of a two-wire serial memory slave. It oversamples the clock and data lines on a fast system clock, recognises bus start and stop conditions, and receives the first byte after a start as a control byte. That byte carries a fixed four-bit device-type code, a half-array select bit, two chip-select bits and a direction bit. When the type code and the chip-select bits both match, the block acknowledges and begins the addressed transfer. On any mismatch it stays silent until the next start.

In a write, the two bytes after the control byte load the low sixteen bits of a 17-bit word address. The half-select bit from the control byte supplies the top bit. Each following data byte is handed to the memory array with a one-cycle strobe, and the address then advances. In a read, the block fetches a byte from the array at the current address, shifts it out MSB first and samples the master's acknowledge after it. A master acknowledge continues the read with the next address, and a not-acknowledge ends it. Address advance always wraps inside the selected half, and the address is held across a repeated start, so a random read is a write of the address followed by a read.

Top module: `ee_addr_front`

## Requirements
- R1: While reset is asserted and right after it, `sda_pull` is 0, `sel_hit` is 0, `wr_strobe` and `rd_strobe` are 0 and `word_addr` is 0.
- R2: A start condition (SDA falling while SCL is high) at any point restarts control byte reception from its first bit. A stop condition (SDA rising while SCL is high) drops `sel_hit`.
- R3: A control byte whose bits 7..4 equal 1010 and whose bits 2..1 equal `strap_sel` (bit 2 against `strap_sel[1]`) makes the block pull SDA low during the ninth SCL pulse, and `sel_hit` goes high.
- R4: A control byte with any other type code or chip-select value gets no acknowledge, and later bytes up to the next start give no acknowledge and no `wr_strobe`.
- R5: Control byte bit 3 becomes `word_addr[16]`. Bit 0 sets `rd_mode`: 1 selects a read and 0 selects a write.
- R6: In a write, the first byte after the control byte loads `word_addr[15:8]` and the second loads `word_addr[7:0]`. Both are acknowledged.
- R7: Each later write byte is acknowledged and produces a single-cycle `wr_strobe` with that byte on `wr_byte` and its target on `word_addr`. The address then advances by one.
- R8: Address advance increments only `word_addr[15:0]`, wrapping 0xFFFF to 0x0000, and never changes `word_addr[16]`.
- R9: In a read, the block pulses `rd_strobe` and shifts out `rd_byte` for the current address MSB first, then releases SDA for the acknowledge slot. The address advances after every byte sent. A master acknowledge continues with the next byte. A not-acknowledge releases SDA and drops `sel_hit`.
- R10: `word_addr[15:0]` keeps its value across a repeated start and a stop, so a read that follows an address write starts at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| strap_sel | input | 2 | Chip-select strap levels |
| rd_byte | input | 8 | Array byte at `word_addr` (combinational read) |
| sda_pull | output | 1 | 1 pulls SDA low |
| sel_hit | output | 1 | Device addressed in the current transfer |
| rd_mode | output | 1 | Direction from the last matched control byte (1 = read) |
| word_addr | output | 17 | Current word address; bit 16 selects the half |
| wr_strobe | output | 1 | One-cycle pulse: write `wr_byte` at `word_addr` |
| wr_byte | output | 8 | Received write data byte |
| rd_strobe | output | 1 | One-cycle pulse: a byte at `word_addr` was taken for sending |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, a 16-bit low address and type code 1010. With these values the wrap from 0xFFFF into 0x0000 can be reached directly by loading addresses near the top of a half, with either value of the half-select bit. The 16-bit width also means the wrap takes only a few bytes of traffic, and the 1010 code and both strap patterns can be driven against matching and non-matching control bytes.

// File: rtl/ee_addr_pkg.sv
package ee_addr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ACK,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT,
    ST_RACK,
    ST_SKIP
  } ee_state_e;
endpackage

// File: rtl/ee_rst_sync.sv
module ee_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_q_n = stage_q[1];
endmodule

// File: rtl/ee_line_sync.sv
module ee_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;
  logic scl_now, sda_now;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_in;
          sda_ff <= sda_in;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_in};
          sda_ff <= {sda_ff[STAGES-2:0], sda_in};
        end
      end
    end
  endgenerate

  assign scl_now = scl_ff[STAGES-1];
  assign sda_now = sda_ff[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_now;
      sda_d <= sda_now;
    end
  end

  assign sda_s    = sda_now;
  assign scl_rise = scl_now & ~scl_d;
  assign scl_fall = ~scl_now & scl_d;
  assign start_ev = scl_now & scl_d & sda_d & ~sda_now;
  assign stop_ev  = scl_now & scl_d & ~sda_d & sda_now;
endmodule

// File: rtl/ee_word_addr.sv
module ee_word_addr #(
  parameter int LO_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_hi,
  input  logic          ld_lo,
  input  logic          set_top,
  input  logic          top_val,
  input  logic          step,
  input  logic [7:0]    din,
  output logic [LO_W:0] addr
);
  localparam int HI_W = LO_W - 8;

  logic [LO_W:0] addr_q, addr_n;

  always_comb begin
    addr_n = addr_q;
    if (set_top) addr_n[LO_W] = top_val;
    if (ld_hi)   addr_n[LO_W-1:8] = din[HI_W-1:0];
    if (ld_lo)   addr_n[7:0] = din;
    if (step)    addr_n[LO_W-1:0] = addr_q[LO_W-1:0] + {{(LO_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_n;
  end

  assign addr = addr_q;
endmodule

// File: rtl/ee_addr_front.sv
module ee_addr_front
  import ee_addr_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         LO_W        = 16,
  parameter logic [3:0] DEV_CODE    = 4'b1010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic [1:0]    strap_sel,
  input  logic [7:0]    rd_byte,
  output logic          sda_pull,
  output logic          sel_hit,
  output logic          rd_mode,
  output logic [LO_W:0] word_addr,
  output logic          wr_strobe,
  output logic [7:0]    wr_byte,
  output logic          rd_strobe
);
  logic rst_q_n;
  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  ee_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  ee_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  ee_state_e st_q, st_n, ret_q, ret_n;
  logic [2:0] bit_q, bit_n;
  logic [7:0] rx_q, rx_n, tx_q, tx_n, wb_q, wb_n;
  logic rw_q, rw_n, ackl_q, ackl_n, incp_q, incp_n, mack_q, mack_n;
  logic drv_q, drv_n, wstb_q, wstb_n, rstb_q, rstb_n;
  logic a_hi, a_lo, a_top, a_inc;
  logic [7:0] shifted;
  logic code_ok;

  assign shifted = {rx_q[6:0], sda_s};
  assign code_ok = (shifted[7:4] == DEV_CODE) && (shifted[2:1] == strap_sel);

  ee_word_addr #(.LO_W(LO_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .ld_hi   (a_hi),
    .ld_lo   (a_lo),
    .set_top (a_top),
    .top_val (shifted[3]),
    .step    (a_inc),
    .din     (shifted),
    .addr    (word_addr)
  );

  // next-state process
  always_comb begin
    st_n   = st_q;
    ret_n  = ret_q;
    bit_n  = bit_q;
    rx_n   = rx_q;
    tx_n   = tx_q;
    wb_n   = wb_q;
    rw_n   = rw_q;
    ackl_n = ackl_q;
    incp_n = incp_q;
    mack_n = mack_q;
    drv_n  = drv_q;
    wstb_n = 1'b0;
    rstb_n = 1'b0;
    a_hi   = 1'b0;
    a_lo   = 1'b0;
    a_top  = 1'b0;
    a_inc  = 1'b0;
    if (start_ev) begin
      st_n   = ST_CTRL;
      bit_n  = 3'd0;
      drv_n  = 1'b0;
      ackl_n = 1'b0;
      incp_n = 1'b0;
    end else if (stop_ev) begin
      st_n   = ST_IDLE;
      drv_n  = 1'b0;
      ackl_n = 1'b0;
      incp_n = 1'b0;
    end else begin
      case (st_q)
        ST_CTRL, ST_AHI, ST_ALO, ST_WDAT: begin
          if (scl_rise) begin
            rx_n  = shifted;
            bit_n = bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              st_n   = ST_ACK;
              ackl_n = 1'b0;
              if (st_q == ST_CTRL) begin
                if (code_ok) begin
                  rw_n  = shifted[0];
                  a_top = 1'b1;
                  ret_n = shifted[0] ? ST_RDAT : ST_AHI;
                end else begin
                  st_n = ST_SKIP;
                end
              end else if (st_q == ST_AHI) begin
                a_hi  = 1'b1;
                ret_n = ST_ALO;
              end else if (st_q == ST_ALO) begin
                a_lo  = 1'b1;
                ret_n = ST_WDAT;
              end else begin
                wstb_n = 1'b1;
                wb_n   = shifted;
                incp_n = 1'b1;
                ret_n  = ST_WDAT;
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (!ackl_q) begin
              drv_n  = 1'b1;
              ackl_n = 1'b1;
            end else begin
              ackl_n = 1'b0;
              st_n   = ret_q;
              bit_n  = 3'd0;
              drv_n  = 1'b0;
              if (incp_q) begin
                a_inc  = 1'b1;
                incp_n = 1'b0;
              end
              if (ret_q == ST_RDAT) begin
                tx_n   = rd_byte;
                drv_n  = ~rd_byte[7];
                rstb_n = 1'b1;
              end
            end
          end
        end
        ST_RDAT: begin
          if (scl_rise) begin
            bit_n = bit_q + 3'd1;
          end else if (scl_fall) begin
            if (bit_q == 3'd0) begin
              st_n  = ST_RACK;
              drv_n = 1'b0;
            end else begin
              tx_n  = {tx_q[6:0], 1'b0};
              drv_n = ~tx_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_n = ~sda_s;
            a_inc  = 1'b1;
          end else if (scl_fall) begin
            if (mack_q) begin
              st_n   = ST_RDAT;
              bit_n  = 3'd0;
              tx_n   = rd_byte;
              drv_n  = ~rd_byte[7];
              rstb_n = 1'b1;
            end else begin
              st_n  = ST_SKIP;
              drv_n = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      st_q   <= ST_IDLE;
      ret_q  <= ST_IDLE;
      bit_q  <= 3'd0;
      rx_q   <= 8'd0;
      tx_q   <= 8'd0;
      wb_q   <= 8'd0;
      rw_q   <= 1'b0;
      ackl_q <= 1'b0;
      incp_q <= 1'b0;
      mack_q <= 1'b0;
      drv_q  <= 1'b0;
      wstb_q <= 1'b0;
      rstb_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      ret_q  <= ret_n;
      bit_q  <= bit_n;
      rx_q   <= rx_n;
      tx_q   <= tx_n;
      wb_q   <= wb_n;
      rw_q   <= rw_n;
      ackl_q <= ackl_n;
      incp_q <= incp_n;
      mack_q <= mack_n;
      drv_q  <= drv_n;
      wstb_q <= wstb_n;
      rstb_q <= rstb_n;
    end
  end

  assign sda_pull  = drv_q;
  assign rd_mode   = rw_q;
  assign wr_strobe = wstb_q;
  assign wr_byte   = wb_q;
  assign rd_strobe = rstb_q;
  assign sel_hit   = (st_q == ST_ACK) || (st_q == ST_AHI) || (st_q == ST_ALO) ||
                     (st_q == ST_WDAT) || (st_q == ST_RDAT) || (st_q == ST_RACK);
endmodule

// File: rtl/ee_addr_front_chk.sv
module ee_addr_front_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_pull,
  input logic sel_hit,
  input logic rd_mode,
  input logic word_top,
  input logic wr_strobe,
  input logic rd_strobe
);
  // R4: silent unless addressed
  p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_hit |-> !sda_pull);

  // R8: the half-select bit never moves within a transfer
  p_top_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hit && $past(sel_hit)) |-> $stable(word_top));

  // R7: write strobes only in an addressed write
  p_wr_ctx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> (sel_hit && !rd_mode));

  // R7: write strobe lasts one cycle
  p_wr_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> !wr_strobe);

  // R9: read fetches only in an addressed read
  p_rd_ctx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |-> (sel_hit && rd_mode));
endmodule

bind ee_addr_front ee_addr_front_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sda_pull  (sda_pull),
  .sel_hit   (sel_hit),
  .rd_mode   (rd_mode),
  .word_top  (word_addr[LO_W]),
  .wr_strobe (wr_strobe),
  .rd_strobe (rd_strobe)
);

// File: tb/ee_addr_front_test.sv
module ee_addr_front_test;
  localparam int CLK_P = 10;
  localparam int H = 8;
  localparam int Q = 6;
  localparam int WD = 190000;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic rst_n, scl, m_sda, sda_line;
  logic [1:0] strap;
  logic [7:0] rd_byte, wr_byte;
  logic sda_pull, sel_hit, rd_mode, wr_strobe, rd_strobe;
  logic [16:0] word_addr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  function automatic logic [7:0] mem_val(input logic [16:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ (a[16] ? 8'hA5 : 8'h3C);
  endfunction

  assign sda_line = m_sda & ~sda_pull;
  assign rd_byte  = mem_val(word_addr);

  ee_addr_front uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl),
    .sda_in    (sda_line),
    .strap_sel (strap),
    .rd_byte   (rd_byte),
    .sda_pull  (sda_pull),
    .sel_hit   (sel_hit),
    .rd_mode   (rd_mode),
    .word_addr (word_addr),
    .wr_strobe (wr_strobe),
    .wr_byte   (wr_byte),
    .rd_strobe (rd_strobe)
  );

  logic [16:0] lw_a [0:255];
  logic [7:0]  lw_d [0:255];
  int lw_n = 0;
  int rs_n = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_strobe) begin
        lw_a[lw_n % 256] = word_addr;
        lw_d[lw_n % 256] = wr_byte;
        lw_n++;
      end
      if (rd_strobe) rs_n++;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; waitc(Q);
    scl = 1'b1;   waitc(H);
    m_sda = 1'b0; waitc(H);
    scl = 1'b0;   waitc(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; waitc(Q);
    scl = 1'b1;   waitc(H);
    m_sda = 1'b1; waitc(H);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; waitc(Q);
    scl = 1'b1; waitc(H);
    scl = 1'b0; waitc(Q);
  endtask

  task automatic xfer(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; waitc(Q);
    scl = 1'b1; waitc(H/2);
    ack = ~sda_line; waitc(H/2);
    scl = 1'b0; waitc(Q);
  endtask

  task automatic get_byte(input logic last, output logic [7:0] v);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitc(Q);
      scl = 1'b1; waitc(H/2);
      v[i] = sda_line; waitc(H/2);
      scl = 1'b0;
    end
    waitc(Q);
    send_bit(last);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic ak;
    logic [7:0] v;
    int base;
    void'($urandom(32'h5EED_1025));
    rst_n = 1'b0; scl = 1'b1; m_sda = 1'b1; strap = 2'b01;
    waitc(4);
    // R1 reset values
    chk("R1", "sda_pull in reset", sda_pull, 0);
    chk("R1", "sel_hit in reset", sel_hit, 0);
    chk("R1", "strobes in reset", {wr_strobe, rd_strobe}, 0);
    chk("R1", "word_addr in reset", word_addr, 0);
    rst_n = 1'b1;
    waitc(6);
    chk("R1", "word_addr after reset", word_addr, 0);

    // R3 R5 R6 R7 write with half 1
    base = lw_n;
    bus_start();
    xfer(8'hAA, ak);
    chk("R3", "control ack", ak, 1);
    chk("R3", "sel_hit after match", sel_hit, 1);
    chk("R5", "rd_mode write", rd_mode, 0);
    chk("R5", "half bit from control", word_addr[16], 1);
    xfer(8'h12, ak); chk("R6", "high byte ack", ak, 1);
    xfer(8'h34, ak); chk("R6", "low byte ack", ak, 1);
    chk("R6", "word_addr loaded", word_addr, 17'h11234);
    for (int k = 0; k < 3; k++) begin
      xfer(8'hC0 + 8'(k), ak);
      chk("R7", "data ack", ak, 1);
    end
    chk("R7", "strobe count", lw_n - base, 3);
    for (int k = 0; k < 3; k++) begin
      chk("R7", "write address", lw_a[(base + k) % 256], 17'h11234 + 17'(k));
      chk("R7", "write data", lw_d[(base + k) % 256], 8'hC0 + 8'(k));
    end
    bus_stop();
    waitc(4);
    chk("R2", "stop drops sel_hit", sel_hit, 0);

    // R8 wrap inside the upper half
    base = lw_n;
    bus_start();
    xfer(8'hAA, ak); xfer(8'hFF, ak); xfer(8'hFE, ak);
    for (int k = 0; k < 3; k++) xfer(8'h50 + 8'(k), ak);
    bus_stop();
    chk("R8", "wrap addr 0", lw_a[base % 256], 17'h1FFFE);
    chk("R8", "wrap addr 1", lw_a[(base + 1) % 256], 17'h1FFFF);
    chk("R8", "wrap addr 2", lw_a[(base + 2) % 256], 17'h10000);
    chk("R8", "address after wrap", word_addr, 17'h10001);

    // R4 wrong type code
    base = lw_n;
    bus_start();
    xfer(8'hBA, ak);
    chk("R4", "no ack on bad code", ak, 0);
    chk("R4", "sel_hit on bad code", sel_hit, 0);
    xfer(8'h00, ak); chk("R4", "no ack on later byte", ak, 0);
    xfer(8'h11, ak);
    bus_stop();
    chk("R4", "no strobes on bad code", lw_n - base, 0);
    chk("R4", "address untouched", word_addr, 17'h10001);

    // R4 wrong strap
    bus_start();
    xfer(8'hA6, ak);
    chk("R4", "no ack on strap mismatch", ak, 0);
    bus_stop();

    // R10 R9 random read
    base = rs_n;
    bus_start();
    xfer(8'hA2, ak); xfer(8'h56, ak); xfer(8'h78, ak);
    bus_start();
    xfer(8'hA3, ak);
    chk("R10", "ack of read control", ak, 1);
    chk("R5", "rd_mode read", rd_mode, 1);
    chk("R10", "address kept over restart", word_addr, 17'h05678);
    for (int k = 0; k < 3; k++) begin
      get_byte(k == 2, v);
      chk("R9", "read byte", v, mem_val(17'h05678 + 17'(k)));
    end
    waitc(4);
    chk("R9", "nack drops sel_hit", sel_hit, 0);
    chk("R9", "nack releases SDA", sda_pull, 0);
    chk("R9", "read strobe count", rs_n - base, 3);
    chk("R9", "address after read", word_addr, 17'h0567B);
    bus_stop();

    // R10 R5 current-address read in upper half
    bus_start();
    xfer(8'hAB, ak);
    get_byte(1'b1, v);
    chk("R10", "current address read", v, mem_val(17'h1567B));
    bus_stop();

    // R2 restart inside a control byte
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    xfer(8'hA2, ak);
    chk("R2", "ack after restart in control byte", ak, 1);
    bus_stop();

    // random traffic
    for (int it = 0; it < 24; it++) begin
      logic hit, b0;
      logic [15:0] a;
      logic [7:0] d [4];
      logic [1:0] sv;
      int n;
      strap = 2'($urandom);
      waitc(2);
      hit = ($urandom % 4) != 0;
      b0 = 1'($urandom);
      a = (it % 4 == 0) ? 16'hFFFF - 16'($urandom % 3) : 16'($urandom);
      n = 1 + int'($urandom % 4);
      sv = hit ? strap : ~strap;
      base = lw_n;
      bus_start();
      xfer({4'b1010, b0, sv, 1'b0}, ak);
      chk(hit ? "R3" : "R4", "random control ack", ak, hit);
      xfer(a[15:8], ak); xfer(a[7:0], ak);
      for (int k = 0; k < n; k++) begin
        d[k] = 8'($urandom);
        xfer(d[k], ak);
      end
      bus_stop();
      if (hit) begin
        chk("R7", "random strobe count", lw_n - base, n);
        for (int k = 0; k < n; k++) begin
          chk("R8", "random write address", lw_a[(base + k) % 256], {b0, a + 16'(k)});
          chk("R7", "random write data", lw_d[(base + k) % 256], d[k]);
        end
      end else begin
        chk("R4", "random no strobes", lw_n - base, 0);
      end
      if (hit && (it % 2 == 1)) begin
        bus_start();
        xfer({4'b1010, b0, strap, 1'b0}, ak);
        xfer(a[15:8], ak); xfer(a[7:0], ak);
        bus_start();
        xfer({4'b1010, b0, strap, 1'b1}, ak);
        for (int k = 0; k < n; k++) begin
          get_byte(k == n - 1, v);
          chk("R9", "random read byte", v, mem_val({b0, a + 16'(k)}));
        end
        bus_stop();
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule